// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin I/O Port

This block is one general-purpose I/O port with a word-addressed register bus. Software drives pins through an output-value register and a drive-enable register, and reads pin levels back after a two-flop synchroniser. Each pin also has its own event detector. A sense-select bit picks edge or level mode, and a polarity bit picks the active direction. A detected event can latch into a sticky status bit if the pin's capture-enable bit is set. A second mask, the interrupt-enable register, decides which latched bits reach the single combined interrupt output.

Every register sits in a 16-byte block. A write at block offset 0x0 loads the whole word. A write at offset 0x4 ORs in the written ones, and a write at offset 0x8 clears the bits written as one. This lets firmware change single bits without a read-modify-write. A read at any of the three offsets returns the register value. The bus has no back-pressure: each access completes in the cycle it is presented, and read data is combinational from the address. The register stream therefore never stalls and needs no ready signal.

Block map, by address bits [6:4]: 0 output value, 1 pin input (read only), 2 drive enable, 3 capture enable, 4 interrupt enable, 5 sense select, 6 polarity, 7 status.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0 and `irq` is low.
- R2: A write at a block's offset 0x0 loads the whole register. Reads at offsets 0x0, 0x4 and 0x8 of that block all return the register value.
- R3: A write at offset 0x4 sets the bits written as 1. A write at offset 0x8 clears the bits written as 1. All other bits keep their values.
- R4: `pad_out` equals the output-value register and `pad_oe` equals the drive-enable register. Neither changes without a write to its block.
- R5: The pin-input block reads the pin levels after two clock edges of synchronisation. Writes to that block are ignored.
- R6: With sense bit 0 (edge), polarity 1 latches on a rising edge and polarity 0 on a falling edge. The opposite edge is ignored. After a pin change, the status bit is readable after the third rising clock edge.
- R7: With sense bit 1 (level), the status bit is set on every cycle the synchronised pin is at its active level (polarity 1 high, 0 low). A clear during that time does not stick; once the level is gone, a clear does.
- R8: An event sets its status bit only when that pin's capture-enable bit is 1.
- R9: Status bits are sticky. Only a write at status offset 0x8 clears them. Writes at status offsets 0x0 and 0x4 are ignored. If an event and a clear hit the same bit in the same cycle, the event wins.
- R10: `irq` is high exactly when some status bit and its interrupt-enable bit are both 1. It follows a register change in the same cycle.
- R11: These accesses are unmapped: offset 0xC of any block, a non-word-aligned address, or any address with bit 7 set. Unmapped writes change nothing and unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Combined port interrupt |

## Verification
The bench targets several timing and priority corners:
- The exact edge at which a status bit first becomes visible. A synchroniser one stage short or long would show the bit a cycle early or late.
- A clear that collides with a persisting level. A design that lets the clear win would drop a live level request.
- Writes at status offsets 0x0 and 0x4. A design that treated status like the other registers would set or wipe pending bits there.
- Opposite-polarity edges, capture-disabled pins and unmapped or misaligned addresses. A wrong design would latch on the wrong edge, leak events past the capture mask, or alias writes into real registers.

A long random run then checks every output against a cycle model on each cycle.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } wr_op_e;

  localparam logic [2:0] BLK_DOUT = 3'd0;
  localparam logic [2:0] BLK_DIN  = 3'd1;
  localparam logic [2:0] BLK_OE   = 3'd2;
  localparam logic [2:0] BLK_CAP  = 3'd3;
  localparam logic [2:0] BLK_IEN  = 3'd4;
  localparam logic [2:0] BLK_LVL  = 3'd5;
  localparam logic [2:0] BLK_POL  = 3'd6;
  localparam logic [2:0] BLK_STAT = 3'd7;

  // writable registers held in the generic register file
  localparam int NUM_SLOTS = 6;
  localparam int SLOT_DOUT = 0;
  localparam int SLOT_OE   = 1;
  localparam int SLOT_CAP  = 2;
  localparam int SLOT_IEN  = 3;
  localparam int SLOT_LVL  = 4;
  localparam int SLOT_POL  = 5;

  function automatic logic [2:0] slot_block(input int slot);
    case (slot)
      SLOT_DOUT: return BLK_DOUT;
      SLOT_OE:   return BLK_OE;
      SLOT_CAP:  return BLK_CAP;
      SLOT_IEN:  return BLK_IEN;
      SLOT_LVL:  return BLK_LVL;
      default:   return BLK_POL;
    endcase
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] slot_hit,
  input  wr_op_e       op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q [N]
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (slot_hit[g]) begin
        case (op)
          OP_LOAD: q[g] <= wdata;
          OP_SET:  q[g] <= q[g] | wdata;
          OP_CLR:  q[g] <= q[g] & ~wdata;
          default: q[g] <= q[g];
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_port_sync.sv
`timescale 1ns/1ps
module gpio_port_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/gpio_port_detect.sv
`timescale 1ns/1ps
module gpio_port_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] pol_sel,
  input  logic [W-1:0] cap_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);

  logic [W-1:0] prev_q;
  logic [W-1:0] active;
  logic [W-1:0] edge_hit;
  logic [W-1:0] evt;

  always_comb begin
    active   = ~(smp ^ pol_sel);
    edge_hit = (smp ^ prev_q) & active;
    evt      = (lvl_sel & active) | (~lvl_sel & edge_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      status <= '0;
    end else begin
      prev_q <= smp;
      status <= (status & ~clr_mask) | (evt & cap_en);
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int W           = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic              irq
);

  localparam int HI_W = ADDR_W - 7;

  logic [2:0]     blk;
  logic [1:0]     op_raw;
  logic           mapped;
  logic           wr_ok;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic [W-1:0]   q [NUM_SLOTS];
  logic [W-1:0]   din_q;
  logic [W-1:0]   status_q;
  logic [W-1:0]   clr_mask;
  logic [W-1:0]   cap_q;
  logic [W-1:0]   ien_q;
  logic [W-1:0]   rd_val;

  assign blk    = bus_addr[6:4];
  assign op_raw = bus_addr[3:2];
  assign mapped = (bus_addr[ADDR_W-1:7] == HI_W'(0)) &&
                  (bus_addr[1:0] == 2'b00) && (op_raw != 2'd3);
  assign wr_ok  = bus_en && bus_we && mapped;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
    assign slot_hit[g] = wr_ok && (blk == slot_block(g));
  end

  assign clr_mask = (wr_ok && blk == BLK_STAT && op_raw == 2'd2) ? bus_wdata : '0;

  gpio_port_regs #(.W(W), .N(NUM_SLOTS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_hit (slot_hit),
    .op       (wr_op_e'(op_raw)),
    .wdata    (bus_wdata),
    .q        (q)
  );

  gpio_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (din_q)
  );

  assign cap_q = q[SLOT_CAP];
  assign ien_q = q[SLOT_IEN];

  gpio_port_detect #(.W(W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (din_q),
    .lvl_sel  (q[SLOT_LVL]),
    .pol_sel  (q[SLOT_POL]),
    .cap_en   (cap_q),
    .clr_mask (clr_mask),
    .status   (status_q)
  );

  always_comb begin
    rd_val = '0;
    if (blk == BLK_DIN) begin
      rd_val = din_q;
    end else if (blk == BLK_STAT) begin
      rd_val = status_q;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (blk == slot_block(i)) rd_val = q[i];
    end
  end

  assign bus_rdata = (bus_en && mapped) ? rd_val : '0;
  assign pad_out   = q[SLOT_DOUT];
  assign pad_oe    = q[SLOT_OE];
  assign irq       = |(status_q & ien_q);

endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe,
  input logic              irq,
  input logic [W-1:0]      status_q,
  input logic [W-1:0]      cap_q,
  input logic [W-1:0]      ien_q
);

  localparam logic [ADDR_W-1:0] STAT_CLR_A = ADDR_W'(8'h78);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && !irq));

  // R4
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R8
  capture_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(cap_q)) == '0));

  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~status_q) != '0) |->
      $past(bus_en && bus_we && bus_addr == STAT_CLR_A));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq      (irq),
  .status_q (status_q),
  .cap_q    (cap_q),
  .ien_q    (ien_q)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

  localparam logic [7:0] A_DOUT = 8'h00, A_DIN = 8'h10, A_OE  = 8'h20, A_CAP = 8'h30;
  localparam logic [7:0] A_IEN  = 8'h40, A_LVL = 8'h50, A_POL = 8'h60, A_STAT = 8'h70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // ---------------- cycle model driven only from bench-side stimulus
  logic [31:0] m_s1, m_s2, m_prev, m_stat;
  logic [31:0] m_dout, m_oe, m_cap, m_ien, m_lvl, m_pol;

  function automatic bit addr_ok(input logic [7:0] a);
    return (a[7] == 1'b0) && (a[1:0] == 2'b00) && (a[3:2] != 2'd3);
  endfunction

  function automatic logic [31:0] upd(input logic [31:0] old);
    case (bus_addr[3:2])
      2'd0:    return bus_wdata;
      2'd1:    return old | bus_wdata;
      2'd2:    return old & ~bus_wdata;
      default: return old;
    endcase
  endfunction

  function automatic logic [31:0] model_evt();
    logic [31:0] act;
    act = ~(m_s2 ^ m_pol);
    return (m_lvl & act) | (~m_lvl & (m_s2 ^ m_prev) & act);
  endfunction

  function automatic logic [31:0] model_clr();
    if (bus_en && bus_we && addr_ok(bus_addr) && bus_addr[6:4] == 3'd7 && bus_addr[3:2] == 2'd2)
      return bus_wdata;
    return '0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (!addr_ok(a)) return '0;
    case (a[6:4])
      3'd0: return m_dout;
      3'd1: return m_s2;
      3'd2: return m_oe;
      3'd3: return m_cap;
      3'd4: return m_ien;
      3'd5: return m_lvl;
      3'd6: return m_pol;
      default: return m_stat;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
      m_dout <= '0; m_oe <= '0; m_cap <= '0; m_ien <= '0; m_lvl <= '0; m_pol <= '0;
    end else begin
      m_s1   <= pad_in;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_stat <= (m_stat & ~model_clr()) | (model_evt() & m_cap);
      if (bus_en && bus_we && addr_ok(bus_addr)) begin
        case (bus_addr[6:4])
          3'd0: m_dout <= upd(m_dout);
          3'd2: m_oe   <= upd(m_oe);
          3'd3: m_cap  <= upd(m_cap);
          3'd4: m_ien  <= upd(m_ien);
          3'd5: m_lvl  <= upd(m_lvl);
          3'd6: m_pol  <= upd(m_pol);
          default: ;
        endcase
      end
    end
  end

  // ---------------- helpers
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic setpad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic idle(input int n);
    bus_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus
  initial begin
    logic [31:0] v;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int b = 0; b < 8; b++) begin
      rd(8'(b * 16), v);
      check("R1 reset register value", v, 32'h0);
    end
    check("R1 pad_oe after reset", pad_oe, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2 load and alias reads
    wr(A_DOUT, 32'hA5A5_0F0F);
    rd(A_DOUT, v);        check("R2 base read", v, 32'hA5A5_0F0F);
    rd(A_DOUT + 8'h4, v); check("R2 set-alias read", v, 32'hA5A5_0F0F);
    rd(A_DOUT + 8'h8, v); check("R2 clear-alias read", v, 32'hA5A5_0F0F);
    check("R4 pad_out follows register", pad_out, 32'hA5A5_0F0F);

    // R3 set / clear aliases
    wr(A_DOUT + 8'h4, 32'h0000_F000);
    rd(A_DOUT, v); check("R3 set alias", v, 32'hA5A5_FF0F);
    wr(A_DOUT + 8'h8, 32'hA500_0000);
    rd(A_DOUT, v); check("R3 clear alias", v, 32'h00A5_FF0F);
    wr(A_OE, 32'hFFFF_0000);
    check("R4 pad_oe follows register", pad_oe, 32'hFFFF_0000);

    // R5 synchronised input, writes ignored
    wr(A_DIN, 32'hFFFF_FFFF);
    setpad(32'h1234_5678);
    rd(A_DIN, v); check("R5 input after one edge", v, 32'h0);
    rd(A_DIN, v); check("R5 input after two edges", v, 32'h1234_5678);

    // R8 events with capture disabled
    setpad(32'h0);
    idle(4);
    rd(A_STAT, v); check("R8 no capture when disabled", v, 32'h0);

    // bit0 rising edge, bit1 falling edge, bit2 high level, bit3 low level
    wr(A_POL, 32'h5);
    wr(A_LVL, 32'hC);
    wr(A_CAP, 32'hF);
    setpad(32'h9);
    rd(A_STAT, v);
    rd(A_STAT, v); check("R6 rising edge not yet latched", v & 32'h1, 32'h0);
    rd(A_STAT, v); check("R6 rising edge latched on third edge", v & 32'h1, 32'h1);

    // R9 sticky, clear alias only
    wr(A_STAT + 8'h8, 32'h1);
    rd(A_STAT, v); check("R9 partial clear keeps others", v, 32'h8);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_STAT + 8'h4, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R9 base and set writes ignored", v, 32'h8);
    wr(A_STAT + 8'h8, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R9 full clear", v, 32'h0);

    // R7 level persistence
    setpad(32'hD);
    idle(3);
    rd(A_STAT, v); check("R7 high level latched", v, 32'h4);
    wr(A_STAT + 8'h8, 32'h4);
    rd(A_STAT, v); check("R7 clear does not stick while active", v, 32'h4);
    setpad(32'h9);
    idle(3);
    wr(A_STAT + 8'h8, 32'h4);
    rd(A_STAT, v); check("R7 clear sticks after level gone", v, 32'h0);

    // R6 falling polarity
    setpad(32'hB);
    idle(3);
    rd(A_STAT, v); check("R6 rise ignored on falling polarity", v, 32'h0);
    setpad(32'h9);
    idle(3);
    rd(A_STAT, v); check("R6 falling edge latched", v, 32'h2);

    // R10 interrupt gating
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h2);
    check("R10 irq raised", {31'h0, irq}, 32'h1);
    wr(A_STAT + 8'h8, 32'h2);
    check("R10 irq dropped after clear", {31'h0, irq}, 32'h0);

    // R11 unmapped and misaligned
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R11 offset 0xC reads zero", v, 32'h0);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(A_DOUT, v); check("R11 unmapped writes ignored", v, 32'h00A5_FF0F);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, v); check("R11 high address reads zero", v, 32'h0);

    // random phase against the cycle model (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      pad_in  = pad_in ^ ($urandom & $urandom & $urandom);
      bus_en  = 1'b1;
      bus_we  = ($urandom % 2) == 0;
      bus_addr = 8'((($urandom % 9) << 4) | (($urandom % 4) << 2));
      if (($urandom % 16) == 0) bus_addr = bus_addr | 8'h2;
      bus_wdata = $urandom;
      #0.5;
      check("R2 R11 random read", bus_rdata, exp_rd(bus_addr));
      check("R10 random irq", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
      check("R4 random pad_out", pad_out, m_dout);
      check("R4 random pad_oe", pad_oe, m_oe);
    end
    bus_en = 1'b0; bus_we = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule